// File: doc/BRIEF.md
# Per-Core Interrupt CPU Interface

This block sits between an interrupt distributor and one processor core. One copy is built for each core. The distributor offers the best candidate it has for this core, as an interrupt ID with a priority. The block compares that candidate against two thresholds: a programmable priority mask, and the running priority of the interrupt the core is already handling. When the candidate beats both thresholds and signalling is enabled, the block raises the core's interrupt request line. A lower priority value means more urgent.

Software reaches the block through a small register port. Reading the acknowledge register returns the candidate's ID. The same read sends an activate pulse to the distributor and pushes the candidate's priority onto a shallow stack of active priorities, so that from then on only more urgent interrupts can preempt. If nothing qualifies, the read returns the spurious ID and changes nothing. Writing an ID to the end-of-interrupt register retires the top stack entry when the IDs match and sends a deactivate pulse to the distributor. The running priority then goes back to the entry below, or to idle once the stack is empty.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A read places its data in a response slot one cycle later. That slot holds `rsp_valid` and `rsp_data` steady until `rsp_ready` is seen high at a clock edge. While a response is waiting and `rsp_ready` is low, `req_ready` stays low, which applies back-pressure to new requests of either kind. Writes produce no response.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, `irq_req` is low, the enable bit reads 0, the priority mask reads 0, the running priority reads idle (all ones in PRIO_W bits), `rsp_valid` is low and the active stack is empty.
- R2: `irq_req` is high exactly when the enable bit is set, `cand_valid` is high, the stack is not full, and `cand_prio` is strictly less than both the priority mask and the running priority. The output is combinational from these inputs and registers.
- R3: The control register is at address 0, and its bit 0 is the enable. When that bit is clear, `irq_req` stays low. Acknowledge qualification ignores the enable bit.
- R4: A read of address 2 (acknowledge) with a qualifying candidate returns `cand_id` on `rsp_data` one cycle after acceptance. In that same cycle it pulses `act_valid` with `act_id` equal to that ID, and the running priority becomes `cand_prio`.
- R5: An acknowledge read with no qualifying candidate returns ID 2^ID_W-1 (1023 at ID_W=10). It raises no `act_valid` and leaves the running priority and the stack unchanged.
- R6: A write to address 3 (end of interrupt) whose low ID_W data bits equal the top stack ID pops that entry. One cycle after acceptance it pulses `deact_valid` with `deact_id` equal to that ID. The running priority then returns to the next entry down, or to idle when the stack empties.
- R7: An end-of-interrupt write whose ID does not match the top entry, or that arrives with an empty stack, raises no `deact_valid` and leaves the running priority unchanged.
- R8: The stack holds DEPTH entries. When it is full, no candidate qualifies, so an acknowledge read returns the spurious ID.
- R9: A pending response holds `rsp_valid` and `rsp_data` steady until `rsp_ready` is seen high. `req_ready` is low exactly while a response is pending and `rsp_ready` is low.
- R10: Address 1 holds the priority mask (read and write). Address 4 reads the running priority. Writes to addresses 2 and 4 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | ID_W | Candidate interrupt ID |
| cand_prio | input | PRIO_W | Candidate priority, lower is more urgent |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 3 | Register address |
| req_wdata | input | REG_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumed |
| rsp_data | output | REG_W | Read response data |
| irq_req | output | 1 | Interrupt request to the core |
| act_valid | output | 1 | Activate pulse to distributor |
| act_id | output | ID_W | ID to mark active |
| deact_valid | output | 1 | Deactivate pulse to distributor |
| deact_id | output | ID_W | ID to deactivate |

## Verification
The bench builds the block with PRIO_W=4, DEPTH=3, ID_W=10 and REG_W=16. With only sixteen priority levels, every pairing of mask value and candidate priority can be swept against the idle running priority, and each expected request level is computed arithmetically. A stack depth of three is small enough for a short nested acknowledge sequence to fill the stack. That exposes the full-stack spurious case, mismatched and empty-stack end-of-interrupt writes, and the restoration of each earlier running priority as the stack unwinds.

// File: rtl/irq_cpu_if_pkg.sv
package irq_cpu_if_pkg;
  typedef enum logic [2:0] {
    ADR_CTRL  = 3'd0,
    ADR_PMASK = 3'd1,
    ADR_ACK   = 3'd2,
    ADR_EOI   = 3'd3,
    ADR_RPRI  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/icpu_prio_stack.sv
module icpu_prio_stack #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [ID_W-1:0]   top_id,
  output logic [PRIO_W-1:0] top_prio,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  depth
);
  logic [ID_W-1:0]   id_mem   [DEPTH];
  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [CNT_W-1:0]  cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign depth = cnt;

  always_comb begin
    top_id   = '0;
    top_prio = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i + 1) == cnt) begin
        top_id   = id_mem[i];
        top_prio = prio_mem[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_mem[i]   <= '0;
        prio_mem[i] <= '1;
      end
    end else if (push && !full) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt) begin
          id_mem[i]   <= push_id;
          prio_mem[i] <= push_prio;
        end
      end
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R8: a push never arrives while the stack is full
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R7: a pop never arrives while the stack is empty
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R4: a stacked priority is always more urgent than the one beneath it
  assert_push_more_urgent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_prio < top_prio));
endmodule

// File: rtl/icpu_gate.sv
module icpu_gate #(
  parameter int PRIO_W = 8
) (
  input  logic              enable,
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [PRIO_W-1:0] running,
  input  logic              stack_full,
  output logic              qualify,
  output logic              irq
);
  logic beats_mask, beats_run;

  assign beats_mask = (cand_prio < pmask);
  assign beats_run  = (cand_prio < running);
  assign qualify    = cand_valid && !stack_full && beats_mask && beats_run;
  assign irq        = enable && qualify;
endmodule

// File: rtl/icpu_rsp_hold.sv
module icpu_rsp_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          can_accept
);
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled response keeps its data
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_if_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  parameter int REG_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [REG_W-1:0]  rsp_data,
  output logic              irq_req,
  output logic              act_valid,
  output logic [ID_W-1:0]   act_id,
  output logic              deact_valid,
  output logic [ID_W-1:0]   deact_id
);
  localparam logic [ID_W-1:0]   SPURIOUS = '1;
  localparam logic [PRIO_W-1:0] IDLE     = '1;

  logic              ctrl_en;
  logic [PRIO_W-1:0] pmask;
  logic [PRIO_W-1:0] running;
  logic              qualify;
  logic              accept, rd_load;
  logic              ack_rd, ack_hit, eoi_hit;
  logic [REG_W-1:0]  rdata;
  logic [ID_W-1:0]   top_id;
  logic [PRIO_W-1:0] top_prio;
  logic              st_empty, st_full;
  logic [CNT_W-1:0]  st_depth;

  assign running = st_empty ? IDLE : top_prio;
  assign accept  = req_valid && req_ready;
  assign rd_load = accept && !req_write;
  assign ack_rd  = rd_load && (req_addr == ADR_ACK);
  assign ack_hit = ack_rd && qualify;
  assign eoi_hit = accept && req_write && (req_addr == ADR_EOI) && !st_empty
                   && (req_wdata[ID_W-1:0] == top_id);

  icpu_gate #(.PRIO_W(PRIO_W)) u_gate (
    .enable     (ctrl_en),
    .cand_valid (cand_valid),
    .cand_prio  (cand_prio),
    .pmask      (pmask),
    .running    (running),
    .stack_full (st_full),
    .qualify    (qualify),
    .irq        (irq_req)
  );

  icpu_prio_stack #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_hit),
    .push_id   (cand_id),
    .push_prio (cand_prio),
    .pop       (eoi_hit),
    .top_id    (top_id),
    .top_prio  (top_prio),
    .empty     (st_empty),
    .full      (st_full),
    .depth     (st_depth)
  );

  always_comb begin
    rdata = '0;
    case (req_addr)
      ADR_CTRL:  rdata[0] = ctrl_en;
      ADR_PMASK: rdata[PRIO_W-1:0] = pmask;
      ADR_ACK:   rdata[ID_W-1:0] = ack_hit ? cand_id : SPURIOUS;
      ADR_RPRI:  rdata[PRIO_W-1:0] = running;
      default:   rdata = '0;
    endcase
  end

  icpu_rsp_hold #(.DW(REG_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (rd_load),
    .load_data  (rdata),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .can_accept (req_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en     <= 1'b0;
      pmask       <= '0;
      act_valid   <= 1'b0;
      act_id      <= '0;
      deact_valid <= 1'b0;
      deact_id    <= '0;
    end else begin
      act_valid   <= ack_hit;
      deact_valid <= eoi_hit;
      if (ack_hit) act_id <= cand_id;
      if (eoi_hit) deact_id <= top_id;
      if (accept && req_write) begin
        if (req_addr == ADR_CTRL)  ctrl_en <= req_wdata[0];
        if (req_addr == ADR_PMASK) pmask   <= req_wdata[PRIO_W-1:0];
      end
    end
  end

  // R3: no request to the core while signalling is disabled
  assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ctrl_en);
  // R4: the activate pulse matches the ID handed back to software
  assert_act_matches_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (rsp_valid && rsp_data[ID_W-1:0] == act_id));
  // R6: each deactivate follows exactly one pop
  assert_deact_pops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> (st_depth == $past(st_depth) - 1'b1));
  // R2: a raised request never targets an idle-level candidate
  assert_irq_not_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cand_valid && cand_prio != IDLE));
endmodule

// File: tb/irq_cpu_if_test.sv
module irq_cpu_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 10, PRIO_W = 4, DEPTH = 3, REG_W = 16;
  localparam int SPUR = (1 << ID_W) - 1;
  localparam int IDLE = (1 << PRIO_W) - 1;

  logic clk = 0, rst_n = 0;
  logic cand_valid = 0;
  logic [ID_W-1:0] cand_id = '0;
  logic [PRIO_W-1:0] cand_prio = '0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [2:0] req_addr = '0;
  logic [REG_W-1:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1;
  logic [REG_W-1:0] rsp_data;
  logic irq_req, act_valid, deact_valid;
  logic [ID_W-1:0] act_id, deact_id;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cpu_if #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq_req(irq_req), .act_valid(act_valid), .act_id(act_id),
    .deact_valid(deact_valid), .deact_id(deact_id));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int last_act_v, last_act_id, last_deact_v, last_deact_id;

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 3'(addr); req_wdata = REG_W'(data);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    last_deact_v = int'(deact_valid); last_deact_id = int'(deact_id);
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 3'(addr);
    @(negedge clk);
    req_valid = 0;
    data = int'(rsp_data);
    last_act_v = int'(act_valid); last_act_id = int'(act_id);
  endtask

  task automatic ack_expect(input string req, input int exp_id, input bit exp_act);
    int d;
    rd(2, d);
    chk(req, d, exp_id);
    chk(req, last_act_v, int'(exp_act));
    if (exp_act) chk(req, last_act_id, exp_id);
  endtask

  task automatic run_expect(input string req, input int exp);
    int d;
    rd(4, d);
    chk(req, d, exp);
  endtask

  task automatic eoi_expect(input string req, input int id, input bit exp_deact);
    wr(3, id);
    chk(req, last_deact_v, int'(exp_deact));
    if (exp_deact) chk(req, last_deact_id, id);
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq_req), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    rd(0, d); chk("R1 enable", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
    run_expect("R1 running", IDLE);

    // R2 R10 sweep: every mask against every candidate priority, idle running
    wr(0, 1);
    cand_valid = 1;
    for (int m = 0; m <= IDLE; m++) begin
      wr(1, m);
      rd(1, d); chk("R10 mask readback", d, m);
      for (int p = 0; p <= IDLE; p++) begin
        cand_prio = PRIO_W'(p);
        #1;
        chk("R2 sweep", int'(irq_req), int'(p < m && p < IDLE));
      end
    end
    cand_valid = 0; cand_prio = 0; #1;
    chk("R2 no candidate", int'(irq_req), 0);
    ack_expect("R5 ack with no candidate", SPUR, 0);

    // R10 writes to read-only addresses ignored
    wr(4, 2); wr(2, 3);
    run_expect("R10 running untouched", IDLE);

    // Nested sequence, mask at maximum
    wr(1, IDLE);
    cand_valid = 1; cand_id = 40; cand_prio = 8; #1;
    chk("R2 idle beats", int'(irq_req), 1);
    ack_expect("R4 ack first", 40, 1);
    run_expect("R4 running first", 8);
    #1 chk("R2 equal priority no irq", int'(irq_req), 0);
    ack_expect("R5 equal priority spurious", SPUR, 0);
    run_expect("R5 running unchanged", 8);
    cand_id = 41; cand_prio = 3; #1;
    chk("R2 preempt", int'(irq_req), 1);
    ack_expect("R4 ack second", 41, 1);
    cand_id = 42; cand_prio = 1;
    ack_expect("R4 ack third", 42, 1);
    run_expect("R4 running third", 1);
    cand_id = 43; cand_prio = 0; #1;
    chk("R8 full no irq", int'(irq_req), 0);
    ack_expect("R8 full spurious", SPUR, 0);
    eoi_expect("R7 mismatch", 40, 0);
    run_expect("R7 running kept", 1);
    eoi_expect("R6 pop third", 42, 1);
    run_expect("R6 restore 3", 3);
    eoi_expect("R6 pop second", 41, 1);
    run_expect("R6 restore 8", 8);
    eoi_expect("R6 pop first", 40, 1);
    run_expect("R6 restore idle", IDLE);
    eoi_expect("R7 empty eoi", 40, 0);
    run_expect("R7 empty running", IDLE);

    // R3 enable clear
    wr(0, 0);
    cand_id = 7; cand_prio = 2; #1;
    chk("R3 irq off", int'(irq_req), 0);
    rd(0, d); chk("R3 enable reads 0", d, 0);
    ack_expect("R3 ack ignores enable", 7, 1);
    eoi_expect("R6 pop after R3", 7, 1);

    // R9 back-pressure
    rsp_ready = 0;
    rd(4, d);
    chk("R9 rsp valid", int'(rsp_valid), 1);
    chk("R9 req_ready low", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk("R9 still valid", int'(rsp_valid), 1);
    chk("R9 data held", int'(rsp_data), IDLE);
    rsp_ready = 1; #1;
    chk("R9 ready follows", int'(req_ready), 1);
    @(negedge clk);
    chk("R9 drained", int'(rsp_valid), 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule